// File: doc/BRIEF.md
# Banked Debug Comparator Register Window

This block holds the programmable state of a four-channel debug comparator unit, together with a sticky match-flag register and an arm control. Software reaches all of it over a simple byte-wide register bus. The bus has a 4-bit address, a write strobe, write data and combinational read data. A bank-select field in the configuration register picks which channel's registers appear in a shared eight-byte window. The stored values drive the external compare logic continuously.

Channels A and C (banks 0 and 2) compare address and data, so each has a control byte, three address bytes, two data bytes and two data-mask bytes. Channels B and D (banks 1 and 3) compare address only. In those two channels the data and mask positions are not implemented, and the control byte carries fewer bits.

The external compare logic reports one match bit per channel. While the unit is armed, a match sets that channel's flag, and the flag stays set. Software can never write the flags. The only way to clear them is to arm the unit again.

Top module: `dbg_cmp_regwin`

## Requirements
- R1: After reset the unit is disarmed and the bank select is 0. Every register, every flag and every comparator output is zero.
- R2: Address 0x0 is the configuration register. A write stores bit 7 as the arm state and bits 1:0 as the bank select. A read returns {arm, 5'b0, bank}.
- R3: Addresses 0x8 to 0xF form the window, and address bits 2:0 give the offset. Offset 0 is control, offsets 1/2/3 are address high/medium/low, offsets 4/5 are data high/low, and offsets 6/7 are mask high/low. Reads and writes reach only the channel chosen by the bank select.
- R4: In channels A and C (banks 0 and 2), all eight window bytes store and read back every bit written.
- R5: In channels B and D (banks 1 and 3), offsets 4 to 7 read zero and ignore writes. Only control bits 5:0 exist (mask 0x3F), and the other control bits read zero.
- R6: For channel i, the outputs are cmp_ctrl[8i+:8], cmp_addr[24i+:24] = {high, medium, low}, cmp_data[16i+:16] = {high, low} and cmp_mask[16i+:16] = {high, low}. Each output reflects a write from the following cycle onward.
- R7: Address 0x1 reads {4'b0, flag D, C, B, A} only while the bank select is 3, and reads zero otherwise. Writes to 0x1 have no effect. Addresses 0x2 to 0x7 read zero.
- R8: While the unit is armed, a high match_in[i] in a cycle with no configuration write sets flag i at the next clock edge. Flags are independent of one another. A flag that is already set is not changed by further matches.
- R9: Matches while the unit is disarmed have no effect. Flags keep their value after a disarm. Only a configuration write with bit 7 set clears them.
- R10: A match in the same cycle as an arming write is not recorded, so the flags come out cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| match_in | input | 4 | Per-channel match from the compare logic, bit i = channel i (A..D) |
| cmp_ctrl | output | 32 | Control byte of each channel |
| cmp_addr | output | 96 | Address compare value of each channel |
| cmp_data | output | 64 | Data compare value of each channel (zero for B, D) |
| cmp_mask | output | 64 | Data mask of each channel (zero for B, D) |

## Verification
Reads are combinational, so the bench sets an address half a cycle away from the rising edge and samples reg_rdata 1 ns later. A register write, a configuration change or a match is applied at one rising edge and becomes visible from that edge on. The bench therefore drives each stimulus on a falling edge and checks it at the next falling edge, exactly one register stage later. The sweep writes a distinct arithmetic pattern to every offset of every bank and predicts each readback and each output from the implemented-bit masks. The flag sequence places single matches, simultaneous matches and a match coincident with arming on known cycles.

// File: rtl/dbg_win_pkg.sv
package dbg_win_pkg;
  localparam int unsigned WIN_BYTES = 8;
  localparam int unsigned OFF_W     = $clog2(WIN_BYTES);

  typedef enum logic [OFF_W-1:0] {
    OFF_CTRL  = 3'd0,
    OFF_ADR_H = 3'd1,
    OFF_ADR_M = 3'd2,
    OFF_ADR_L = 3'd3,
    OFF_DAT_H = 3'd4,
    OFF_DAT_L = 3'd5,
    OFF_MSK_H = 3'd6,
    OFF_MSK_L = 3'd7
  } win_off_e;

  localparam logic [3:0] ADDR_CFG   = 4'h0;
  localparam logic [3:0] ADDR_FLAGS = 4'h1;
endpackage

// File: rtl/dbg_cmp_bank.sv
module dbg_cmp_bank
  import dbg_win_pkg::*;
#(
  parameter bit         HAS_DATA  = 1'b1,
  parameter logic [7:0] CTRL_MASK = 8'hFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] off,
  input  logic [7:0]       wdata,
  output logic [7:0]       rd_byte,
  output logic [7:0]       ctrl,
  output logic [23:0]      addr,
  output logic [15:0]      data,
  output logic [15:0]      mask
);
  logic [WIN_BYTES-1:0][7:0] bytes_q;

  // Implemented bits per offset; the rest are never stored.
  function automatic logic [7:0] byte_mask(input logic [OFF_W-1:0] o);
    if (o == OFF_CTRL) return CTRL_MASK;
    if (!HAS_DATA && o >= OFF_DAT_H) return 8'h00;
    return 8'hFF;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) bytes_q <= '0;
    else if (wr_en) bytes_q[off] <= wdata & byte_mask(off);
  end

  assign rd_byte = bytes_q[off];
  assign ctrl    = bytes_q[OFF_CTRL];
  assign addr    = {bytes_q[OFF_ADR_H], bytes_q[OFF_ADR_M], bytes_q[OFF_ADR_L]};

  generate
    if (HAS_DATA) begin : g_data
      assign data = {bytes_q[OFF_DAT_H], bytes_q[OFF_DAT_L]};
      assign mask = {bytes_q[OFF_MSK_H], bytes_q[OFF_MSK_L]};
    end else begin : g_nodata
      assign data = '0;
      assign mask = '0;
      // R5: absent positions read as zero
      a_r5_absent_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (off >= OFF_DAT_H) |-> (rd_byte == 8'h00));
    end
  endgenerate

  // R3: storage holds unless written
  a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(bytes_q));

  // R6: a control write reaches the output one cycle later
  a_r6_ctrl_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && off == OFF_CTRL) |=> (ctrl == ($past(wdata) & CTRL_MASK)));
endmodule

// File: rtl/dbg_match_flags.sv
module dbg_match_flags #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_wr,
  input  logic           arm_val,
  input  logic [NCH-1:0] match,
  output logic           armed,
  output logic [NCH-1:0] flags
);
  logic           armed_q;
  logic [NCH-1:0] flags_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      flags_q <= '0;
    end else if (cfg_wr) begin
      armed_q <= arm_val;
      if (arm_val) flags_q <= '0;
    end else if (armed_q) begin
      flags_q <= flags_q | match;
    end
  end

  assign armed = armed_q;
  assign flags = flags_q;

  // R9: a flag only falls after an arming write
  a_r9_clear_only_by_arm: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(flags_q) & ~flags_q)) |-> $past(cfg_wr && arm_val));

  // R8: a new flag needs the unit armed and that channel matching
  a_r8_set_needs_armed: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags_q & ~$past(flags_q))) |-> $past(armed_q && !cfg_wr));

  a_r8_set_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags_q & ~$past(flags_q))) |-> ((flags_q & ~$past(flags_q) & ~$past(match)) == '0));

  // R10: arming leaves the flags clear even with a match present
  a_r10_arm_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && arm_val) |=> (flags_q == '0));
endmodule

// File: rtl/dbg_cmp_regwin.sv
module dbg_cmp_regwin
  import dbg_win_pkg::*;
#(
  parameter int unsigned NCH            = 4,
  parameter logic [7:0]  CTRL_MASK_DATA = 8'hFF,
  parameter logic [7:0]  CTRL_MASK_ADDR = 8'h3F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       reg_addr,
  input  logic             reg_we,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic [NCH-1:0]   match_in,
  output logic [NCH*8-1:0]  cmp_ctrl,
  output logic [NCH*24-1:0] cmp_addr,
  output logic [NCH*16-1:0] cmp_data,
  output logic [NCH*16-1:0] cmp_mask
);
  localparam int unsigned BSEL_W = $clog2(NCH);

  logic [BSEL_W-1:0] bank_q;
  logic              cfg_wr, win_hit, win_we, armed;
  logic [NCH-1:0]    flags;
  logic [7:0]        ch_rd [NCH];
  logic [OFF_W-1:0]  win_off;

  assign win_hit = reg_addr[3];
  assign win_we  = reg_we && win_hit;
  assign win_off = reg_addr[OFF_W-1:0];
  assign cfg_wr  = reg_we && (reg_addr == ADDR_CFG);

  always_ff @(posedge clk) begin
    if (!rst_n) bank_q <= '0;
    else if (cfg_wr) bank_q <= reg_wdata[BSEL_W-1:0];
  end

  dbg_match_flags #(.NCH(NCH)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_wr  (cfg_wr),
    .arm_val (reg_wdata[7]),
    .match   (match_in),
    .armed   (armed),
    .flags   (flags)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam bit HAS_D = ((c % 2) == 0);
      dbg_cmp_bank #(
        .HAS_DATA  (HAS_D),
        .CTRL_MASK (HAS_D ? CTRL_MASK_DATA : CTRL_MASK_ADDR)
      ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (win_we && (bank_q == BSEL_W'(c))),
        .off     (win_off),
        .wdata   (reg_wdata),
        .rd_byte (ch_rd[c]),
        .ctrl    (cmp_ctrl[c*8 +: 8]),
        .addr    (cmp_addr[c*24 +: 24]),
        .data    (cmp_data[c*16 +: 16]),
        .mask    (cmp_mask[c*16 +: 16])
      );
    end
  endgenerate

  always_comb begin
    reg_rdata = 8'h00;
    if (win_hit) begin
      reg_rdata = ch_rd[bank_q];
    end else if (reg_addr == ADDR_CFG) begin
      reg_rdata = {armed, 7'(bank_q)};
    end else if (reg_addr == ADDR_FLAGS && (&bank_q)) begin
      reg_rdata = 8'(flags);
    end
  end

  // R7: flags stay hidden unless the last bank is selected
  a_r7_flags_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_FLAGS && !(&bank_q)) |-> (reg_rdata == 8'h00));

  // R2: bank select changes only through a configuration write
  a_r2_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_wr) |-> $stable(bank_q));
endmodule

// File: tb/dbg_cmp_regwin_bench.sv
module dbg_cmp_regwin_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [3:0]  match_in = '0;
  logic [31:0] cmp_ctrl;
  logic [95:0] cmp_addr;
  logic [63:0] cmp_data, cmp_mask;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dbg_cmp_regwin u_dbg_cmp_regwin (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .match_in(match_in),
    .cmp_ctrl(cmp_ctrl), .cmp_addr(cmp_addr), .cmp_data(cmp_data), .cmp_mask(cmp_mask)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse_match(input logic [3:0] m);
    @(negedge clk);
    match_in = m;
    @(negedge clk);
    match_in = '0;
  endtask

  function automatic logic [7:0] pat(input int b, input int o);
    return 8'(b * 37 + o * 11 + 5);
  endfunction

  function automatic logic [7:0] emask(input int b, input int o);
    if (o == 0) return (b % 2 == 0) ? 8'hFF : 8'h3F;
    if (o >= 4 && (b % 2) == 1) return 8'h00;
    return 8'hFF;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      chk("R1 reset read", 32'(d), 32'h0);
    end
    chk("R1 reset ctrl", cmp_ctrl, 32'h0);
    chk("R1 reset addr", 32'(|cmp_addr), 32'h0);
    chk("R1 reset data/mask", 32'(|{cmp_data, cmp_mask}), 32'h0);

    // R3 R4 R5: fill every bank with a distinct pattern
    for (int b = 0; b < 4; b++) begin
      wr(4'h0, 8'(b));
      for (int o = 0; o < 8; o++) wr(4'(8 + o), pat(b, o));
    end
    for (int b = 0; b < 4; b++) begin
      wr(4'h0, 8'(b));
      rd(4'h0, d);
      chk("R2 cfg readback", 32'(d), 32'(b));
      for (int o = 0; o < 8; o++) begin
        rd(4'(8 + o), d);
        chk((b % 2 == 0) ? "R4 full bank readback" : "R5 narrow bank readback",
            32'(d), 32'(pat(b, o) & emask(b, o)));
      end
    end

    // R6: comparator outputs
    for (int b = 0; b < 4; b++) begin
      chk("R6 ctrl out", 32'(cmp_ctrl[b*8 +: 8]), 32'(pat(b, 0) & emask(b, 0)));
      chk("R6 addr out", 32'(cmp_addr[b*24 +: 24]), {8'h0, pat(b, 1), pat(b, 2), pat(b, 3)});
      chk("R6 data out", 32'(cmp_data[b*16 +: 16]),
          (b % 2 == 0) ? {16'h0, pat(b, 4), pat(b, 5)} : 32'h0);
      chk("R6 mask out", 32'(cmp_mask[b*16 +: 16]),
          (b % 2 == 0) ? {16'h0, pat(b, 6), pat(b, 7)} : 32'h0);
    end

    // R5: all-ones writes to a narrow bank
    wr(4'h0, 8'h01);
    wr(4'h8, 8'hFF);
    wr(4'hC, 8'hFF);
    rd(4'h8, d); chk("R5 narrow ctrl mask", 32'(d), 32'h3F);
    rd(4'hC, d); chk("R5 narrow data ignored", 32'(d), 32'h0);
    chk("R5 narrow data out", 32'(cmp_data[16 +: 16]), 32'h0);

    // R7: unused addresses
    for (int a = 2; a < 8; a++) begin
      rd(4'(a), d);
      chk("R7 unused address", 32'(d), 32'h0);
    end

    // R9: disarmed matches ignored (bank 3 so flags are visible)
    wr(4'h0, 8'h03);
    pulse_match(4'hF);
    rd(4'h1, d); chk("R9 disarmed match", 32'(d), 32'h0);

    // R8: armed matches
    wr(4'h0, 8'h83);
    rd(4'h0, d); chk("R2 armed readback", 32'(d), 32'h83);
    pulse_match(4'b0001);
    rd(4'h1, d); chk("R8 flag A", 32'(d), 32'h1);
    pulse_match(4'b0001);
    rd(4'h1, d); chk("R8 repeat match", 32'(d), 32'h1);
    pulse_match(4'b0100);
    rd(4'h1, d); chk("R8 independent flag C", 32'(d), 32'h5);

    // R7: hidden from other banks, not writable
    wr(4'h0, 8'h80 | 8'h00);
    rd(4'h1, d); chk("R7 hidden bank0 / R10 rearm", 32'(d), 32'h0);
    wr(4'h0, 8'h83);
    pulse_match(4'b1010);
    wr(4'h0, 8'h02);
    pulse_match(4'b0101);
    rd(4'h1, d); chk("R7 hidden bank2", 32'(d), 32'h0);
    wr(4'h0, 8'h03);
    rd(4'h1, d); chk("R9 kept after disarm", 32'(d), 32'hA);
    wr(4'h1, 8'hFF);
    rd(4'h1, d); chk("R7 flag write ignored", 32'(d), 32'hA);
    rd(4'h0, d); chk("R2 disarmed readback", 32'(d), 32'h03);

    // R10: match coincident with arming write
    wr(4'h0, 8'h83);
    pulse_match(4'b0010);
    rd(4'h1, d); chk("R8 armed again", 32'(d), 32'h2);
    @(negedge clk);
    reg_addr = 4'h0; reg_wdata = 8'h83; reg_we = 1'b1; match_in = 4'b1101;
    @(negedge clk);
    reg_we = 1'b0; match_in = '0;
    rd(4'h1, d); chk("R10 match during arm", 32'(d), 32'h0);
    pulse_match(4'b1111);
    rd(4'h1, d); chk("R8 all channels", 32'(d), 32'hF);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule